// File: doc/BRIEF.md
# Shadowed Configuration Sync Engine for a Serial-Programmed Synthesizer

This block holds two copies of each of six 32-bit configuration registers for a frequency synthesizer that is programmed over a write-only serial link. The first copy is the value the host wants. The second copy is the value the device was last given. The host loads the wanted copies through a small register port and then strobes a sync request. The engine walks the registers from the top index down. For each register whose two copies disagree, it shifts out one 32-bit word on an SPI-style master interface, then sets the last-given copy equal to the wanted copy.

In the target device, some fields are double-buffered and only take effect when register 0 is written. For this reason, the engine also sends register 0 whenever register 1 or register 4 went out earlier in the same pass, even if register 0 itself has not changed. Each word carries the register index in its three low bits. The host cannot set those bits: they are cleared on every host write. Reads return the copy last sent to the device. This lets the host see what the device actually holds.

Top module: `synth_cfg_sync`

## Requirements
- R1: After reset, every last-sent copy reads as 0xFFFFFFFF. busy, done and host_err are low, spi_le is high and spi_sclk is low. The first sync after reset therefore sends all six registers.
- R2: In a pass, a register is sent only when its wanted copy differs from its last-sent copy. R4 is the one exception.
- R3: Within a pass, words go out in strictly descending register index, from 5 down to 0.
- R4: If register 1 or register 4 is sent in a pass, register 0 is also sent last in that pass, even when it is unchanged.
- R5: Each word is 32 bits long. Bits [31:3] are the wanted value and bits [2:0] are the register index. The word is shifted MSB first during one low period of spi_le.
- R6: A host write stores the supplied data with bits [2:0] forced to zero.
- R7: Once a register has been sent, its last-sent copy equals the wanted copy. A host read returns the last-sent copy one cycle after host_re, not the wanted copy.
- R8: A host access (host_we or host_re) with host_idx above 5 raises host_err for exactly one cycle, on the cycle after the access. It changes no stored value and leaves host_rdata unchanged.
- R9: The serial clock idles low and data is captured on its rising edge. Data stays stable while spi_sclk is high. spi_sclk stays low whenever spi_le is high. spi_le stays high for at least one full serial clock period (2*HALF_DIV cycles) between words.
- R10: busy rises on the cycle after an accepted sync_req and stays high for the whole pass. A sync_req that arrives while busy is high is ignored and does not start another pass.
- R11: done pulses high for exactly one cycle at the end of every pass, including a pass that sends nothing. busy is low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_we | input | 1 | Write strobe for the wanted copy |
| host_re | input | 1 | Read strobe for the last-sent copy |
| host_idx | input | 3 | Register index for host access |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid the cycle after host_re |
| host_err | output | 1 | One-cycle pulse for an out-of-range index |
| sync_req | input | 1 | Start a sync pass |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data, MSB first |
| spi_le | output | 1 | Latch enable, low during a word |

## Verification
The hardest case to reach is a forced rewrite of register 0. It needs a pass in which register 1 or register 4 differs while register 0 does not. The bench reaches it by first syncing everything, so that both copies agree, and then changing only register 1, or only register 4, or registers 4 and 3 together. This exposes both the forced word and its position after every other word. A behavioural model holds both copies and predicts each pass's word list. A port-level decoder rebuilds the words from the serial pins on every clock, and a second sync_req is raised in the middle of a pass to show it has no effect.

// File: rtl/cfg_sync_pkg.sv
package cfg_sync_pkg;
  typedef enum logic [1:0] {SC_IDLE, SC_SCAN, SC_WAIT} scan_st_t;
  typedef enum logic [1:0] {TX_IDLE, TX_SHIFT, TX_GAP} tx_st_t;
endpackage

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank #(
  parameter int NUM_REGS = 6,
  parameter int REG_W    = 32,
  parameter int IDX_W    = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            host_we,
  input  logic                            host_re,
  input  logic [IDX_W-1:0]                host_idx,
  input  logic [REG_W-1:0]                host_wdata,
  input  logic                            upd_en,
  input  logic [IDX_W-1:0]                upd_idx,
  output logic [REG_W-1:0]                host_rdata,
  output logic                            host_err,
  output logic [NUM_REGS-1:0][REG_W-1:0]  want_vals,
  output logic [NUM_REGS-1:0]             diff_vec
);
  localparam logic [REG_W-1:0] LOW_MASK = REG_W'((1 << IDX_W) - 1);

  logic [NUM_REGS-1:0][REG_W-1:0] want_q;
  logic [NUM_REGS-1:0][REG_W-1:0] sent_q;
  logic                           idx_ok;
  logic [REG_W-1:0]               rd_mux;
  logic [REG_W-1:0]               rdata_q;
  logic                           err_q;

  assign idx_ok = (host_idx < IDX_W'(NUM_REGS));

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic want_en;
    logic sent_en;
    assign want_en = host_we && (host_idx == IDX_W'(g));
    assign sent_en = upd_en && (upd_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        want_q[g] <= '0;
      end else if (want_en) begin
        want_q[g] <= host_wdata & ~LOW_MASK;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sent_q[g] <= '1;
      end else if (sent_en) begin
        sent_q[g] <= want_q[g];
      end
    end

    assign diff_vec[g] = (want_q[g] != sent_q[g]);
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (host_idx == IDX_W'(i)) rd_mux = sent_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (host_re && idx_ok) begin
      rdata_q <= rd_mux;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= (host_we || host_re) && !idx_ok;
  end

  assign host_rdata = rdata_q;
  assign host_err   = err_q;
  assign want_vals  = want_q;

  p_err_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_we || host_re) && (host_idx >= IDX_W'(NUM_REGS))) |=> host_err);

  p_err_rdata_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_err |-> $stable(host_rdata));
endmodule

// File: rtl/cfg_scan_ctrl.sv
module cfg_scan_ctrl
  import cfg_sync_pkg::*;
#(
  parameter int                  NUM_REGS   = 6,
  parameter int                  IDX_W      = 3,
  parameter logic [NUM_REGS-1:0] FORCE_MASK = 6'b010010
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sync_req,
  input  logic [NUM_REGS-1:0] diff_vec,
  input  logic                tx_done,
  output logic                busy,
  output logic                done,
  output logic                tx_start,
  output logic [IDX_W-1:0]    sel_idx
);
  scan_st_t         st_q, st_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             frc_q, frc_n;
  logic             done_q, done_n;
  logic             start_c;
  logic             send_c;

  assign send_c = diff_vec[idx_q] || ((idx_q == '0) && frc_q);

  always_comb begin
    st_n    = st_q;
    idx_n   = idx_q;
    frc_n   = frc_q;
    done_n  = 1'b0;
    start_c = 1'b0;
    case (st_q)
      SC_IDLE: begin
        if (sync_req) begin
          st_n  = SC_SCAN;
          idx_n = IDX_W'(NUM_REGS - 1);
          frc_n = 1'b0;
        end
      end
      SC_SCAN: begin
        if (send_c) begin
          start_c = 1'b1;
          st_n    = SC_WAIT;
          if (FORCE_MASK[idx_q]) frc_n = 1'b1;
        end else if (idx_q == '0) begin
          st_n   = SC_IDLE;
          done_n = 1'b1;
        end else begin
          idx_n = idx_q - IDX_W'(1);
        end
      end
      SC_WAIT: begin
        if (tx_done) begin
          if (idx_q == '0) begin
            st_n   = SC_IDLE;
            done_n = 1'b1;
          end else begin
            st_n  = SC_SCAN;
            idx_n = idx_q - IDX_W'(1);
          end
        end
      end
      default: st_n = SC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SC_IDLE;
      idx_q  <= '0;
      frc_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      idx_q  <= idx_n;
      frc_q  <= frc_n;
      done_q <= done_n;
    end
  end

  assign busy     = (st_q != SC_IDLE);
  assign done     = done_q;
  assign tx_start = start_c;
  assign sel_idx  = idx_q;

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ends_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_force_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SC_SCAN && idx_q == '0 && frc_q) |-> tx_start);

  p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx_q < IDX_W'(NUM_REGS)));

  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_n) |=> busy);
endmodule

// File: rtl/cfg_spi_tx.sv
module cfg_spi_tx
  import cfg_sync_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  output logic              tx_done,
  output logic              sclk,
  output logic              mosi,
  output logic              le
);
  localparam int CNT_W = $clog2(2 * HALF_DIV + 1);
  localparam int BIT_W = $clog2(WORD_W);

  tx_st_t            st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BIT_W-1:0]  bit_q, bit_n;
  logic [WORD_W-1:0] sh_q, sh_n;
  logic              sclk_q, sclk_n;
  logic              le_q, le_n;
  logic              done_q, done_n;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    bit_n  = bit_q;
    sh_n   = sh_q;
    sclk_n = sclk_q;
    le_n   = le_q;
    done_n = 1'b0;
    case (st_q)
      TX_IDLE: begin
        if (start) begin
          st_n   = TX_SHIFT;
          sh_n   = word;
          le_n   = 1'b0;
          sclk_n = 1'b0;
          cnt_n  = '0;
          bit_n  = '0;
        end
      end
      TX_SHIFT: begin
        if (cnt_q == CNT_W'(HALF_DIV - 1)) begin
          cnt_n = '0;
          if (!sclk_q) begin
            sclk_n = 1'b1;
          end else begin
            sclk_n = 1'b0;
            if (bit_q == BIT_W'(WORD_W - 1)) begin
              le_n = 1'b1;
              st_n = TX_GAP;
            end else begin
              bit_n = bit_q + BIT_W'(1);
              sh_n  = {sh_q[WORD_W-2:0], 1'b0};
            end
          end
        end else begin
          cnt_n = cnt_q + CNT_W'(1);
        end
      end
      TX_GAP: begin
        if (cnt_q == CNT_W'(2 * HALF_DIV - 1)) begin
          cnt_n  = '0;
          st_n   = TX_IDLE;
          done_n = 1'b1;
        end else begin
          cnt_n = cnt_q + CNT_W'(1);
        end
      end
      default: st_n = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      sclk_q <= 1'b0;
      le_q   <= 1'b1;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      bit_q  <= bit_n;
      sh_q   <= sh_n;
      sclk_q <= sclk_n;
      le_q   <= le_n;
      done_q <= done_n;
    end
  end

  assign tx_done = done_q;
  assign sclk    = sclk_q;
  assign mosi    = sh_q[WORD_W-1];
  assign le      = le_q;

  p_sclk_low_le_r9: assert property (@(posedge clk) disable iff (!rst_n)
    le |-> !sclk);

  p_mosi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  p_start_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (st_q == TX_IDLE));
endmodule

// File: rtl/synth_cfg_sync.sv
module synth_cfg_sync #(
  parameter int NUM_REGS  = 6,
  parameter int REG_W     = 32,
  parameter int IDX_W     = 3,
  parameter int HALF_DIV  = 2,
  parameter logic [NUM_REGS-1:0] FORCE_MASK = 6'b010010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic             host_re,
  input  logic [IDX_W-1:0] host_idx,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] host_rdata,
  output logic             host_err,
  input  logic             sync_req,
  output logic             busy,
  output logic             done,
  output logic             spi_sclk,
  output logic             spi_mosi,
  output logic             spi_le
);
  logic [1:0]                     rs_q;
  logic                           rst_int_n;
  logic [NUM_REGS-1:0][REG_W-1:0] want_vals;
  logic [NUM_REGS-1:0]            diff_vec;
  logic                           tx_start;
  logic                           tx_done;
  logic [IDX_W-1:0]               sel_idx;
  logic [REG_W-1:0]               tx_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  always_comb begin
    tx_word = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (sel_idx == IDX_W'(i)) tx_word = want_vals[i] | REG_W'(i);
    end
  end

  cfg_shadow_bank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .IDX_W(IDX_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .host_we   (host_we),
    .host_re   (host_re),
    .host_idx  (host_idx),
    .host_wdata(host_wdata),
    .upd_en    (tx_start),
    .upd_idx   (sel_idx),
    .host_rdata(host_rdata),
    .host_err  (host_err),
    .want_vals (want_vals),
    .diff_vec  (diff_vec)
  );

  cfg_scan_ctrl #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .FORCE_MASK(FORCE_MASK)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .sync_req(sync_req),
    .diff_vec(diff_vec),
    .tx_done (tx_done),
    .busy    (busy),
    .done    (done),
    .tx_start(tx_start),
    .sel_idx (sel_idx)
  );

  cfg_spi_tx #(.WORD_W(REG_W), .HALF_DIV(HALF_DIV)) u_tx (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start  (tx_start),
    .word   (tx_word),
    .tx_done(tx_done),
    .sclk   (spi_sclk),
    .mosi   (spi_mosi),
    .le     (spi_le)
  );
endmodule

// File: tb/sim_synth_cfg_sync.sv
`timescale 1ns/1ps
module sim_synth_cfg_sync;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic        host_re = 1'b0;
  logic [2:0]  host_idx = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_err;
  logic        sync_req = 1'b0;
  logic        busy;
  logic        done;
  logic        spi_sclk;
  logic        spi_mosi;
  logic        spi_le;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  int done_cnt = 0;

  logic [31:0] m_want [6];
  logic [31:0] m_sent [6];
  logic [31:0] got_q [$];

  logic        prev_sclk = 1'b0;
  logic        prev_le = 1'b1;
  logic        prev_done = 1'b0;
  logic [31:0] shreg = '0;
  int          nbits = 0;
  int          gap_cnt = 0;
  bit          seen_word = 1'b0;

  always #2 clk = ~clk;

  synth_cfg_sync u0 (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
    .host_idx(host_idx), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_err(host_err), .sync_req(sync_req), .busy(busy), .done(done),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_le(spi_le)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Port-level monitor: rebuilds words and checks framing on every clock
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (!spi_le && spi_sclk && !prev_sclk) begin
        shreg = {shreg[30:0], spi_mosi};
        nbits++;
      end
      if (spi_le && spi_sclk) check(1'b0, "R9 sclk high while le high", 32'd1, 32'd0);
      if (spi_le && !prev_le) begin
        check(nbits == 32, "R5 bits per word", 32'(nbits), 32'd32);
        got_q.push_back(shreg);
        nbits = 0;
        gap_cnt = 0;
        seen_word = 1'b1;
      end
      if (spi_le) gap_cnt++;
      if (!spi_le && prev_le && seen_word)
        check(gap_cnt >= 4, "R9 le high gap", 32'(gap_cnt), 32'd4);
      if (done) begin
        done_cnt++;
        if (busy) check(1'b0, "R11 busy during done", 32'd1, 32'd0);
        if (prev_done) check(1'b0, "R11 done wider than one cycle", 32'd2, 32'd1);
      end
      prev_sclk = spi_sclk;
      prev_le   = spi_le;
      prev_done = done;
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cycles > 150000) begin
        tests++;
        fails++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        finish_run();
      end
    end
  end

  task automatic do_write(input int idx, input logic [31:0] val);
    @(posedge clk); #1;
    host_we = 1'b1; host_idx = 3'(idx); host_wdata = val;
    @(posedge clk); #1;
    host_we = 1'b0;
    if (idx < 6) m_want[idx] = val & 32'hFFFF_FFF8;
  endtask

  task automatic do_read(input int idx, input logic [31:0] exp, input string req);
    @(posedge clk); #1;
    host_re = 1'b1; host_idx = 3'(idx);
    @(posedge clk); #1;
    host_re = 1'b0;
    @(negedge clk);
    check(host_rdata == exp, req, host_rdata, exp);
  endtask

  // Model: predicts the word list of a pass from both copies
  task automatic do_sync(input string req, input bit poke_busy);
    logic [31:0] exp_q [$];
    bit force0;
    int d0;
    int wait_c;
    force0 = 1'b0;
    for (int i = 5; i >= 0; i--) begin
      if (m_want[i] != m_sent[i] || (i == 0 && force0)) begin
        exp_q.push_back(m_want[i] | 32'(i));
        m_sent[i] = m_want[i];
        if (i == 1 || i == 4) force0 = 1'b1;
      end
    end
    got_q.delete();
    d0 = done_cnt;
    @(posedge clk); #1;
    sync_req = 1'b1;
    @(posedge clk); #1;
    sync_req = 1'b0;
    @(negedge clk);
    check(busy == 1'b1, "R10 busy after sync", 32'(busy), 32'd1);
    if (poke_busy) begin
      repeat (20) @(negedge clk);
      #1 sync_req = 1'b1;
      repeat (3) @(negedge clk);
      #1 sync_req = 1'b0;
    end
    wait_c = 0;
    while (!done && wait_c < 5000) begin
      @(negedge clk);
      wait_c++;
    end
    repeat (40) @(negedge clk);
    check(done_cnt == d0 + 1, "R11 one done per pass", 32'(done_cnt - d0), 32'd1);
    check(busy == 1'b0, "R10 idle after pass", 32'(busy), 32'd0);
    check(got_q.size() == exp_q.size(), {req, " word count"},
          32'(got_q.size()), 32'(exp_q.size()));
    for (int k = 0; k < exp_q.size(); k++) begin
      if (k < got_q.size())
        check(got_q[k] == exp_q[k], {req, " word"}, got_q[k], exp_q[k]);
    end
  endtask

  initial begin
    for (int i = 0; i < 6; i++) begin
      m_want[i] = '0;
      m_sent[i] = '1;
    end
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(busy == 0, "R1 busy", 32'(busy), 0);
    check(done == 0, "R1 done", 32'(done), 0);
    check(host_err == 0, "R1 err", 32'(host_err), 0);
    check(spi_le == 1, "R1 le", 32'(spi_le), 1);
    check(spi_sclk == 0, "R1 sclk", 32'(spi_sclk), 0);
    for (int i = 0; i < 6; i++) do_read(i, 32'hFFFF_FFFF, "R1 sent copy reset");

    // R1/R3/R5/R6: first sync sends all, descending, low bits replaced by index
    do_write(0, 32'h1111_1117);
    do_write(1, 32'h2222_2225);
    do_write(2, 32'h3333_3333);
    do_write(3, 32'h4444_4440);
    do_write(4, 32'h5555_5556);
    do_write(5, 32'h6666_6661);
    do_read(2, 32'hFFFF_FFFF, "R7 read returns sent copy before sync");
    do_sync("R3 full pass", 1'b0);
    for (int i = 0; i < 6; i++) do_read(i, m_sent[i], "R7 sent copy after sync");

    do_sync("R11 empty pass", 1'b0);

    do_write(2, 32'h0ABC_DEF7);
    do_sync("R2 only reg2", 1'b0);

    do_write(1, 32'h7777_7770);
    do_sync("R4 reg1 forces reg0", 1'b0);

    do_write(4, 32'h0000_1238);
    do_sync("R4 reg4 forces reg0", 1'b0);

    do_write(4, 32'h0000_5678);
    do_write(3, 32'h0F0F_0F0F);
    do_sync("R4 reg4 and reg3 then reg0", 1'b0);

    do_write(0, 32'h0000_00F0);
    do_sync("R2 only reg0", 1'b0);

    // R8 out-of-range access
    do_read(5, m_sent[5], "R7 prime rdata");
    do_write(6, 32'hDEAD_BEEF);
    @(negedge clk);
    check(host_err == 1, "R8 err on write idx 6", 32'(host_err), 1);
    @(negedge clk);
    check(host_err == 0, "R8 err one cycle", 32'(host_err), 0);
    do_read(7, m_sent[5], "R8 rdata unchanged on bad read");
    check(host_err == 1, "R8 err on read idx 7", 32'(host_err), 1);
    do_sync("R8 bad write stored nothing", 1'b0);

    // R10 sync ignored while busy
    do_write(5, 32'h1357_9BD8);
    do_write(2, 32'h2468_ACE0);
    do_sync("R10 pass with extra requests", 1'b1);

    // R6 low bits cleared
    do_write(3, 32'hFFFF_FFFF);
    do_sync("R6 reg3 all ones", 1'b0);
    do_read(3, 32'hFFFF_FFF8, "R6 stored low bits zero");

    finish_run();
  end
endmodule